// File: doc/BRIEF.md
# Dual-Rail Precharge Pipeline

This block is a clocked model of a latchless asynchronous pipeline. It has a chain of stages and carries dual-rail data with four-phase, return-to-zero signalling. Every stage is a function block that either evaluates or precharges. No register sits between stages. A stage keeps its token because it holds its evaluated output until it is told to precharge, and while it precharges it ignores its input and drives all rails low. The stage that follows decides when a stage precharges: the completion detector on that next stage's output controls it. The right-hand neighbour's acknowledge controls the last stage.

Each evaluate or precharge takes `PHASE_CYC` clock cycles. A stage whose bit in `INV_MASK` is set swaps the two rails of every bit, which inverts the carried value. Any other stage passes the value through unchanged. The left environment drives a codeword, waits for `in_ack` to rise, drives the spacer, and waits for `in_ack` to fall. The right environment raises `out_ack` after it has taken a codeword from `data_out`, and lowers it once `data_out` has returned to the spacer.

Top module: `dr_precharge_pipe`

## Requirements
- R1: Bit k uses rails [2k+1] (true) and [2k] (false). A value of 1 is 10, a value of 0 is 01 and 00 is the spacer. No stage output and no `data_out` ever shows 11 on a rail pair.
- R2: `in_ack` is a C-element over stage 0's per-bit rail ORs. It rises only when every bit of stage 0 is valid, and it falls only when every bit of stage 0 is 00.
- R3: A stage precharges while its control is high and evaluates while its control is low. The control of stage i is the completion output of stage i+1, and the control of the last stage is `out_ack`. While `out_ack` stays low, `data_out` keeps its codeword.
- R4: A stage that is precharging and already at the spacer stays at the spacer whatever its input does. In particular, stage 0 does not accept a waiting input, and `in_ack` stays low.
- R5: Once a stage holds a codeword, the codeword does not change until the stage returns to the spacer, even if its input changes.
- R6: A stage with its `INV_MASK` bit set swaps the rails of every bit. `data_out` carries the input value XOR all-ones when an odd number of mask bits are set, and carries the input value unchanged otherwise.
- R7: After reset every stage output is the spacer, every stage is evaluating, `in_ack` is 0 and `data_out` is 0.
- R8: A codeword applied to an empty pipeline appears complete on `data_out` exactly `STAGES*PHASE_CYC` clock edges later.
- R9: Tokens leave in the order they entered. `data_out` always returns to the spacer between two tokens and never changes directly from one codeword to another.
- R10: With `out_ack` held low, an empty pipeline of even `STAGES` accepts exactly `STAGES/2` tokens, one every two stages.
- R11: Each stage output is, as a whole, either the spacer or a complete codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that times the evaluate and precharge phases |
| rst_n | input | 1 | Active-low synchronous reset |
| data_in | input | 2*BITS | Dual-rail input codeword or spacer |
| in_ack | output | 1 | Completion of stage 0; acknowledge to the left environment |
| data_out | output | 2*BITS | Dual-rail output of the last stage |
| out_ack | input | 1 | Completion from the right environment; precharges the last stage |

## Verification
The bench stalls the output with `out_ack` held low and counts how many tokens the left side gets in. A design that dropped the spacer between tokens would take all `STAGES` tokens, and a precharging stage that leaked its input would raise `in_ack` for the waiting token. While the output is stalled the bench also watches `data_out`: a last stage that precharged without `out_ack` would lose the codeword. Values such as all zeros, all ones and alternating patterns, sent back to back with varying acknowledge delays, expose a rail swap in the wrong stage, tokens that are reordered or dropped, and a codeword that changes into the next one without a spacer in between. The first token's arrival time exposes any extra or missing cycle in the per-stage phase timing.

// File: rtl/dr_precharge_pipe.sv
module dr_precharge_pipe #(
  parameter int STAGES    = 6,
  parameter int BITS      = 4,
  parameter int PHASE_CYC = 2,
  parameter logic [STAGES-1:0] INV_MASK = 6'b000001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2*BITS-1:0] data_in,
  output logic              in_ack,
  output logic [2*BITS-1:0] data_out,
  input  logic              out_ack
);
  localparam int DW = 2 * BITS;
  localparam int CW = $clog2(PHASE_CYC + 1);

  function automatic logic all_valid(input logic [DW-1:0] v);
    logic r;
    r = 1'b1;
    for (int k = 0; k < BITS; k++) r = r & (v[2*k+1] | v[2*k]);
    return r;
  endfunction

  function automatic logic [DW-1:0] swap_rails(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int k = 0; k < BITS; k++) r[2*k +: 2] = {v[2*k], v[2*k+1]};
    return r;
  endfunction

  logic [STAGES-1:0][DW-1:0] stg;
  logic [STAGES-1:0][DW-1:0] din;
  logic [STAGES-1:0][CW-1:0] cnt;
  logic [STAGES-1:0]         cd, cdq, ctl;

  assign ctl      = {out_ack, cd[STAGES-1:1]};
  assign in_ack   = cd[0];
  assign data_out = stg[STAGES-1];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic          empty, go;
    logic [DW-1:0] fval;

    if (i == 0) begin : g_src
      assign din[i] = data_in;
    end else begin : g_src
      assign din[i] = stg[i-1];
    end

    if (INV_MASK[i]) begin : g_fn
      assign fval = swap_rails(din[i]);
    end else begin : g_fn
      assign fval = din[i];
    end

    assign empty = (stg[i] == '0);
    assign cd[i] = all_valid(stg[i]) | (cdq[i] & ~empty);
    assign go    = ctl[i] ? ~empty : (empty & all_valid(din[i]));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[i] <= '0;
        cnt[i] <= '0;
        cdq[i] <= 1'b0;
      end else begin
        cdq[i] <= cd[i];
        if (!go) begin
          cnt[i] <= '0;
        end else if (cnt[i] == CW'(PHASE_CYC - 1)) begin
          cnt[i] <= '0;
          stg[i] <= ctl[i] ? '0 : fval;
        end else begin
          cnt[i] <= cnt[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dr_precharge_pipe_chk.sv
module dr_precharge_pipe_chk #(
  parameter int STAGES = 6,
  parameter int BITS   = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [STAGES-1:0][2*BITS-1:0]  stg,
  input logic [STAGES-1:0]              cd,
  input logic                           out_ack
);
  localparam int DW = 2 * BITS;

  function automatic logic full_word(input logic [DW-1:0] v);
    logic r;
    r = 1'b1;
    for (int k = 0; k < BITS; k++) r = r & (v[2*k+1] ^ v[2*k]);
    return r;
  endfunction

  function automatic logic no_clash(input logic [DW-1:0] v);
    logic r;
    r = 1'b1;
    for (int k = 0; k < BITS; k++) r = r & ~(v[2*k+1] & v[2*k]);
    return r;
  endfunction

  logic [STAGES-1:0] ctl;
  assign ctl = {out_ack, cd[STAGES-1:1]};

  AST_CD_RISE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cd[0]) |-> full_word(stg[0])); // R2
  AST_CD_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cd[0]) |-> (stg[0] == '0)); // R2
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stg[STAGES-1] != '0 && !out_ack) |=> (stg[STAGES-1] != '0)); // R3

  for (genvar i = 0; i < STAGES; i++) begin : g_chk
    AST_NO_RAIL_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      no_clash(stg[i])); // R1
    AST_PRECHARGE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl[i] && stg[i] == '0) |=> (stg[i] == '0)); // R4
    AST_TOKEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (stg[i] != '0) |=> (stg[i] == $past(stg[i]) || stg[i] == '0)); // R5
    AST_ALL_OR_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (stg[i] == '0) || full_word(stg[i])); // R11
  end
endmodule

bind dr_precharge_pipe dr_precharge_pipe_chk #(.STAGES(STAGES), .BITS(BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .stg(stg), .cd(cd), .out_ack(out_ack)
);

// File: tb/dr_precharge_pipe_tb.sv
module dr_precharge_pipe_tb;
  localparam int STAGES = 6;
  localparam int BITS   = 4;
  localparam int PHASE_CYC = 2;
  localparam logic [STAGES-1:0] INV_MASK = 6'b000001;
  localparam int DW = 2 * BITS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] data_in = '0;
  logic in_ack;
  logic [DW-1:0] data_out;
  logic out_ack = 1'b0;

  always #4 clk = ~clk;

  dr_precharge_pipe #(.STAGES(STAGES), .BITS(BITS), .PHASE_CYC(PHASE_CYC), .INV_MASK(INV_MASK)) u_dut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .in_ack(in_ack),
    .data_out(data_out), .out_ack(out_ack)
  );

  int checks = 0, fails = 0, cyc = 0, rises = 0, t0 = -1, got = 0;
  logic prev_ack = 1'b0;
  logic stall = 1'b0;
  logic [BITS-1:0] expq[$];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_ack <= in_ack;
    if (rst_n && in_ack && !prev_ack) rises <= rises + 1;
  end

  function automatic logic [DW-1:0] enc(input logic [BITS-1:0] v);
    logic [DW-1:0] r;
    for (int k = 0; k < BITS; k++) r[2*k +: 2] = v[k] ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic logic is_full(input logic [DW-1:0] v);
    logic r;
    r = 1'b1;
    for (int k = 0; k < BITS; k++) r = r & (v[2*k+1] ^ v[2*k]);
    return r;
  endfunction

  function automatic logic [BITS-1:0] xform(input logic [BITS-1:0] v);
    return ($countones(INV_MASK) % 2 == 1) ? ~v : v;
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [BITS-1:0] v);
    while (in_ack) @(negedge clk);
    data_in = enc(v);
    expq.push_back(xform(v));
    if (t0 < 0) t0 = cyc;
    while (!in_ack) @(negedge clk);
    data_in = '0;
  endtask

  initial begin : monitor
    logic [DW-1:0] held;
    int n = 0;
    @(posedge rst_n);
    forever begin
      do @(negedge clk); while (!is_full(data_out));
      held = data_out;
      if (n == 0) check(cyc - t0 == STAGES * PHASE_CYC, "R8 latency", cyc - t0, STAGES * PHASE_CYC);
      if (expq.size() == 0) check(1'b0, "R9 unexpected token", held, 0);
      else check(held == enc(expq[0]), "R6 R9 value/order", held, enc(expq[0]));
      if (expq.size() > 0) void'(expq.pop_front());
      got++;
      repeat ((n * 3) % 4) @(negedge clk);
      while (stall) @(negedge clk);
      out_ack = 1'b1;
      while (data_out != '0) begin
        if (data_out != held) check(1'b0, "R9 no spacer between tokens", data_out, held);
        @(negedge clk);
      end
      out_ack = 1'b0;
      n++;
    end
  end

  task automatic run_main();
    logic [DW-1:0] snap;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_out == '0, "R7 data_out after reset", data_out, 0);
    check(in_ack == 1'b0, "R7 in_ack after reset", in_ack, 0);
    send(4'h0); send(4'hF); send(4'hA); send(4'h5);
    for (int v = 0; v < 12; v++) send(BITS'(v * 7 + 3));
    while (expq.size() != 0 || out_ack || data_out != '0) @(negedge clk);
    stall = 1'b1;
    r0 = rises;
    fork
      begin send(4'h1); send(4'h2); send(4'h3); send(4'h4); send(4'h9); end
    join_none
    repeat (150) @(negedge clk);
    check(rises - r0 == STAGES / 2, "R10 stalled capacity", rises - r0, STAGES / 2);
    check(in_ack == 1'b0, "R4 waiting token not accepted", in_ack, 0);
    snap = data_out;
    repeat (20) @(negedge clk);
    check(data_out == snap && data_out == enc(xform(4'h1)), "R3 output held without ack", data_out, enc(xform(4'h1)));
    stall = 1'b0;
    wait fork;
    while (expq.size() != 0 || out_ack || data_out != '0) @(negedge clk);
    check(got == 21, "R9 token count", got, 21);
    check(data_out == '0 && in_ack == 1'b0, "R1 idle spacer", data_out, 0);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R9 watchdog", 0, 1);
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule